// File: doc/BRIEF.md
# Board Control Register Bank

This block is a small word-addressed register bank that a board presents to its host processor. Through a single read/write port the host reads a fixed board identity word and drives eight user indicator LEDs. It can also read the synchronised state of a memory-card slot and of the master-site strap, and control the active-low write-protect line of a flash device. Two flag words serve as scratch state shared between boot stages. Each is read at its base offset. A write to that same offset ORs bits in, and a write to the next word clears the bits given in the data.

One flag word is volatile and is cleared by the soft reset. The other is non-volatile and is cleared only by the power-on reset. A boot loader can therefore leave a message in it that survives a warm restart. Both reset inputs are asserted asynchronously and released synchronously inside the block. Reads are registered: the data of a read request appears on the read bus one clock after the request and stays there until the next read.

Top module: `sysctl_regbank`

## Requirements
- R1: While either reset is held, and after release until the first access, `led_o`, `flash_wp_n_o` and `rdata` are zero, and both flag words read zero.
- R2: A read of byte offset 0x000 returns the parameter BOARD_ID in bits 27:16 and zero elsewhere. A write to that offset changes nothing that a later read returns.
- R3: A write to offset 0x008 loads wdata bits 7:0 onto `led_o`, one bit per LED, on the clock edge of the write. A read of 0x008 returns those bits with zero above them.
- R4: A write to offset 0x030 ORs wdata into the volatile flag word. A read of 0x030 returns the flag word.
- R5: A write to offset 0x034 clears every volatile flag bit that is 1 in wdata and leaves the other bits unchanged. A read of 0x034 returns zero.
- R6: Offsets 0x038 (read and set) and 0x03C (clear) give the same semantics for the non-volatile flag word. Accesses to either flag word leave the other word unchanged.
- R7: Pulsing `rst_n` low with `por_n` high clears the volatile flags, the LEDs and the flash control and keeps the non-volatile flags. Pulsing `por_n` low also clears the non-volatile flags.
- R8: A read of offset 0x048 returns the card-present pin in bit 0 and the card write-protect pin in bit 1, each after two synchronising flops. After a pin change, the first two reads issued on consecutive clocks still return the old value, and the third returns the new one. Writes to 0x048 are ignored.
- R9: Bit 0 of offset 0x048+4 (0x04C) is a read/write control bit that drives `flash_wp_n_o` directly. A value of 0 write-protects the flash.
- R10: A read of offset 0x060 returns the synchronised master-site strap in bit 14 and zero elsewhere. A 1 in bit 14 selects the second daughterboard site as master.
- R11: A read of any offset not listed above returns zero. `rdata` keeps the result of the last read while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, asynchronous active low |
| por_n | input | 1 | Power-on reset, asynchronous active low; also resets everything the soft reset does |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| card_present_i | input | 1 | Card-present pin, asynchronous |
| card_wprot_i | input | 1 | Card write-protect pin, asynchronous |
| master_strap_i | input | 1 | Master-site strap, asynchronous |
| led_o | output | LED_N | User LED drives |
| flash_wp_n_o | output | 1 | Flash write-protect, active low |

## Verification
The bench sets BOARD_ID to 12'h5A3. This non-zero, asymmetric pattern shows whether the identity field lands in bits 27:16 or is shifted or truncated. The other parameters keep their defaults: an 8-bit byte offset, eight LEDs, a two-flop synchroniser and bit 14 for the master strap. With two synchroniser stages, the exact read on which a card-pin change first becomes visible can be predicted and checked. With the 8-bit offset, every mapped word and several unmapped holes fall within reach.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int REG_W = 32;

  // byte offsets of the mapped words
  localparam logic [7:0] OFF_ID      = 8'h00;
  localparam logic [7:0] OFF_LED     = 8'h08;
  localparam logic [7:0] OFF_VFLAG   = 8'h30;
  localparam logic [7:0] OFF_VCLR    = 8'h34;
  localparam logic [7:0] OFF_NVFLAG  = 8'h38;
  localparam logic [7:0] OFF_NVCLR   = 8'h3C;
  localparam logic [7:0] OFF_CARD    = 8'h48;
  localparam logic [7:0] OFF_FLASH   = 8'h4C;
  localparam logic [7:0] OFF_MISC    = 8'h60;

  localparam int ID_LSB = 16;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ID,
    SEL_LED,
    SEL_VFLAG,
    SEL_VCLR,
    SEL_NVFLAG,
    SEL_NVCLR,
    SEL_CARD,
    SEL_FLASH,
    SEL_MISC
  } sel_e;

endpackage

// File: rtl/sysctl_rst_sync.sv
module sysctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/sysctl_pin_sync.sv
module sysctl_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = pin_i;
    for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign pin_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sysctl_flagword.sv
module sysctl_flagword #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags
);

  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;
  logic         upd;

  always_comb begin
    upd     = set_en | clr_en;
    flags_d = flags_q;
    if (set_en) flags_d = flags_d | wdata;
    // clear is applied last so it wins over a coincident set
    if (clr_en) flags_d = flags_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [11:0] BOARD_ID    = 12'h000,
  parameter int          LED_N       = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          MASTER_BIT  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              card_present_i,
  input  logic              card_wprot_i,
  input  logic              master_strap_i,
  output logic [LED_N-1:0]  led_o,
  output logic              flash_wp_n_o
);

  localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(OFF_ID);
  localparam logic [ADDR_W-1:0] A_LED    = ADDR_W'(OFF_LED);
  localparam logic [ADDR_W-1:0] A_VFLAG  = ADDR_W'(OFF_VFLAG);
  localparam logic [ADDR_W-1:0] A_VCLR   = ADDR_W'(OFF_VCLR);
  localparam logic [ADDR_W-1:0] A_NVFLAG = ADDR_W'(OFF_NVFLAG);
  localparam logic [ADDR_W-1:0] A_NVCLR  = ADDR_W'(OFF_NVCLR);
  localparam logic [ADDR_W-1:0] A_CARD   = ADDR_W'(OFF_CARD);
  localparam logic [ADDR_W-1:0] A_FLASH  = ADDR_W'(OFF_FLASH);
  localparam logic [ADDR_W-1:0] A_MISC   = ADDR_W'(OFF_MISC);
  localparam int                N_FLAG   = 2;
  localparam int                N_PIN    = 3;
  localparam logic [REG_W-1:0]  ID_WORD  = REG_W'(BOARD_ID) << ID_LSB;

  // reset domains: volatile (either reset) and non-volatile (power-on only)
  logic vrst_n;
  logic nvrst_n;
  logic vrst_raw_n;

  assign vrst_raw_n = rst_n & por_n;

  sysctl_rst_sync #(.STAGES(2)) u_vrst (
    .clk    (clk),
    .arst_n (vrst_raw_n),
    .srst_n (vrst_n)
  );

  sysctl_rst_sync #(.STAGES(2)) u_nvrst (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (nvrst_n)
  );

  // pin synchronisers: {strap, wprot, present}
  logic [N_PIN-1:0] pins_raw;
  logic [N_PIN-1:0] pins_s;

  assign pins_raw = {master_strap_i, card_wprot_i, card_present_i};

  sysctl_pin_sync #(.WIDTH(N_PIN), .STAGES(SYNC_STAGES)) u_pins (
    .clk   (clk),
    .rst_n (vrst_n),
    .pin_i (pins_raw),
    .pin_o (pins_s)
  );

  // address decode
  sel_e sel;

  always_comb begin
    unique case (addr)
      A_ID:     sel = SEL_ID;
      A_LED:    sel = SEL_LED;
      A_VFLAG:  sel = SEL_VFLAG;
      A_VCLR:   sel = SEL_VCLR;
      A_NVFLAG: sel = SEL_NVFLAG;
      A_NVCLR:  sel = SEL_NVCLR;
      A_CARD:   sel = SEL_CARD;
      A_FLASH:  sel = SEL_FLASH;
      A_MISC:   sel = SEL_MISC;
      default:  sel = SEL_NONE;
    endcase
  end

  // flag words: index 0 volatile, index 1 non-volatile
  logic [REG_W-1:0] flag_word [N_FLAG];
  logic [REG_W-1:0] vflags;
  logic [REG_W-1:0] nvflags;

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    logic set_hit;
    logic clr_hit;
    logic fw_rst_n;

    if (g == 0) begin : g_vol
      assign set_hit  = wr_en && (sel == SEL_VFLAG);
      assign clr_hit  = wr_en && (sel == SEL_VCLR);
      assign fw_rst_n = vrst_n;
    end else begin : g_nonvol
      assign set_hit  = wr_en && (sel == SEL_NVFLAG);
      assign clr_hit  = wr_en && (sel == SEL_NVCLR);
      assign fw_rst_n = nvrst_n;
    end

    sysctl_flagword #(.W(REG_W)) u_fw (
      .clk    (clk),
      .rst_n  (fw_rst_n),
      .set_en (set_hit),
      .clr_en (clr_hit),
      .wdata  (wdata),
      .flags  (flag_word[g])
    );
  end

  assign vflags  = flag_word[0];
  assign nvflags = flag_word[1];

  // LED and flash control
  logic [LED_N-1:0] led_q, led_d;
  logic             led_en;
  logic             flash_q, flash_d;
  logic             flash_en;

  always_comb begin
    led_en   = wr_en && (sel == SEL_LED);
    led_d    = wdata[LED_N-1:0];
    flash_en = wr_en && (sel == SEL_FLASH);
    flash_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge vrst_n) begin
    if (!vrst_n) begin
      led_q   <= '0;
      flash_q <= 1'b0;
    end else begin
      if (led_en)   led_q   <= led_d;
      if (flash_en) flash_q <= flash_d;
    end
  end

  assign led_o        = led_q;
  assign flash_wp_n_o = flash_q;

  // read path
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] rdata_q;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_ID:     rd_mux = ID_WORD;
      SEL_LED:    rd_mux = REG_W'(led_q);
      SEL_VFLAG:  rd_mux = vflags;
      SEL_NVFLAG: rd_mux = nvflags;
      SEL_CARD:   rd_mux = REG_W'(pins_s[1:0]);
      SEL_FLASH:  rd_mux = REG_W'(flash_q);
      SEL_MISC:   rd_mux = REG_W'(pins_s[2]) << MASTER_BIT;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge vrst_n) begin
    if (!vrst_n)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [11:0] BOARD_ID   = 12'h000,
  parameter int          LED_N      = 8
) (
  input logic              clk,
  input logic              vrst_n,
  input logic              nvrst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic [REG_W-1:0]  rdata,
  input logic [LED_N-1:0]  led_o,
  input logic              flash_wp_n_o,
  input logic [REG_W-1:0]  vflags,
  input logic [REG_W-1:0]  nvflags
);

  localparam logic [ADDR_W-1:0] C_ID     = ADDR_W'(OFF_ID);
  localparam logic [ADDR_W-1:0] C_LED    = ADDR_W'(OFF_LED);
  localparam logic [ADDR_W-1:0] C_VFLAG  = ADDR_W'(OFF_VFLAG);
  localparam logic [ADDR_W-1:0] C_VCLR   = ADDR_W'(OFF_VCLR);
  localparam logic [ADDR_W-1:0] C_NVFLAG = ADDR_W'(OFF_NVFLAG);
  localparam logic [ADDR_W-1:0] C_NVCLR  = ADDR_W'(OFF_NVCLR);
  localparam logic [ADDR_W-1:0] C_FLASH  = ADDR_W'(OFF_FLASH);
  localparam logic [REG_W-1:0]  C_IDW    = {4'b0, BOARD_ID, 16'b0};

  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (!vrst_n)
    (rd_en && addr == C_ID) |=> rdata == C_IDW);

  // R3
  led_write_chk: assert property (@(posedge clk) disable iff (!vrst_n)
    (wr_en && addr == C_LED) |=> led_o == $past(wdata[LED_N-1:0]));

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!vrst_n)
    (wr_en && addr == C_VFLAG) |=> (vflags & $past(wdata)) == $past(wdata));

  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!vrst_n)
    (wr_en && addr == C_VCLR) |=> (vflags & $past(wdata)) == '0);

  // R6
  nv_hold_chk: assert property (@(posedge clk) disable iff (!nvrst_n)
    !(wr_en && (addr == C_NVFLAG || addr == C_NVCLR)) |=> $stable(nvflags));

  // R9
  flash_write_chk: assert property (@(posedge clk) disable iff (!vrst_n)
    (wr_en && addr == C_FLASH) |=> flash_wp_n_o == $past(wdata[0]));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(
  .ADDR_W   (ADDR_W),
  .BOARD_ID (BOARD_ID),
  .LED_N    (LED_N)
) u_chk (
  .clk          (clk),
  .vrst_n       (vrst_n),
  .nvrst_n      (nvrst_n),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .led_o        (led_o),
  .flash_wp_n_o (flash_wp_n_o),
  .vflags       (vflags),
  .nvflags      (nvflags)
);

// File: tb/sim_sysctl_regbank.sv
`timescale 1ns/1ps
module sim_sysctl_regbank;

  localparam int          ADDR_W = 8;
  localparam logic [11:0] BID    = 12'h5A3;
  localparam int          LED_N  = 8;

  logic              clk = 1'b0;
  logic              rst_n, por_n;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic              card_present_i, card_wprot_i, master_strap_i;
  logic [LED_N-1:0]  led_o;
  logic              flash_wp_n_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sysctl_regbank #(
    .ADDR_W   (ADDR_W),
    .BOARD_ID (BID),
    .LED_N    (LED_N)
  ) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .por_n          (por_n),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .addr           (addr),
    .wdata          (wdata),
    .rdata          (rdata),
    .card_present_i (card_present_i),
    .card_wprot_i   (card_wprot_i),
    .master_strap_i (master_strap_i),
    .led_o          (led_o),
    .flash_wp_n_o   (flash_wp_n_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_reset(input logic soft_only);
    rst_n = 1'b0;
    if (!soft_only) por_n = 1'b0;
    idle(3);
    rst_n = 1'b1; por_n = 1'b1;
    idle(4);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 led", 32'(led_o), 32'h0);
    check("R1 flash", 32'(flash_wp_n_o), 32'h0);
    check("R1 rdata", rdata, 32'h0);
    rd(8'h30, d); check("R1 vflags", d, 32'h0);
    rd(8'h38, d); check("R1 nvflags", d, 32'h0);
  endtask

  task automatic t_id;
    logic [31:0] d;
    rd(8'h00, d); check("R2 id", d, 32'h05A3_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R2 id after write", d, 32'h05A3_0000);
  endtask

  task automatic t_led;
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_F1A5);
    check("R3 led pins", 32'(led_o), 32'hA5);
    rd(8'h08, d); check("R3 led readback", d, 32'hA5);
    wr(8'h08, 32'h0000_0003);
    check("R3 led pins 2", 32'(led_o), 32'h03);
  endtask

  task automatic t_flags;
    logic [31:0] d;
    wr(8'h30, 32'h0000_00F0);
    rd(8'h30, d); check("R4 set", d, 32'h0000_00F0);
    wr(8'h30, 32'h0F00_0001);
    rd(8'h30, d); check("R4 or", d, 32'h0F00_00F1);
    wr(8'h34, 32'h0000_0031);
    rd(8'h30, d); check("R5 clear", d, 32'h0F00_00C0);
    rd(8'h34, d); check("R5 clear alias reads zero", d, 32'h0);
  endtask

  task automatic t_nv;
    logic [31:0] d;
    wr(8'h38, 32'hDEAD_0000);
    rd(8'h38, d); check("R6 nv set", d, 32'hDEAD_0000);
    rd(8'h30, d); check("R6 volatile untouched", d, 32'h0F00_00C0);
    wr(8'h3C, 32'h00AD_0000);
    rd(8'h38, d); check("R6 nv clear", d, 32'hDE00_0000);
    rd(8'h30, d); check("R6 volatile untouched 2", d, 32'h0F00_00C0);
  endtask

  task automatic t_resets;
    logic [31:0] d;
    wr(8'h4C, 32'h1);
    do_reset(1'b1);
    check("R7 soft led", 32'(led_o), 32'h0);
    check("R7 soft flash", 32'(flash_wp_n_o), 32'h0);
    rd(8'h30, d); check("R7 soft vflags", d, 32'h0);
    rd(8'h38, d); check("R7 soft keeps nv", d, 32'hDE00_0000);
    do_reset(1'b0);
    rd(8'h38, d); check("R7 por clears nv", d, 32'h0);
  endtask

  task automatic t_card;
    logic [31:0] d;
    card_present_i = 1'b1; card_wprot_i = 1'b1;
    rd(8'h48, d); check("R8 first read old", d, 32'h0);
    rd(8'h48, d); check("R8 second read old", d, 32'h0);
    rd(8'h48, d); check("R8 third read new", d, 32'h3);
    wr(8'h48, 32'h0);
    rd(8'h48, d); check("R8 write ignored", d, 32'h3);
    card_present_i = 1'b0;
    idle(3);
    rd(8'h48, d); check("R8 wprot only", d, 32'h2);
  endtask

  task automatic t_flash;
    logic [31:0] d;
    wr(8'h4C, 32'hFFFF_FFFF);
    check("R9 flash pin high", 32'(flash_wp_n_o), 32'h1);
    rd(8'h4C, d); check("R9 flash readback", d, 32'h1);
    wr(8'h4C, 32'h0);
    check("R9 flash pin low", 32'(flash_wp_n_o), 32'h0);
  endtask

  task automatic t_misc;
    logic [31:0] d;
    master_strap_i = 1'b1;
    idle(3);
    rd(8'h60, d); check("R10 strap second site", d, 32'h0000_4000);
    master_strap_i = 1'b0;
    idle(3);
    rd(8'h60, d); check("R10 strap first site", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'h00, d);
    idle(3);
    check("R11 rdata holds", rdata, 32'h05A3_0000);
    rd(8'h10, d); check("R11 hole 0x10", d, 32'h0);
    rd(8'h24, d); check("R11 hole 0x24", d, 32'h0);
    rd(8'h31, d); check("R11 unaligned", d, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; por_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    card_present_i = 1'b0; card_wprot_i = 1'b0; master_strap_i = 1'b0;
    idle(2);
    check("R1 rdata in reset", rdata, 32'h0);
    check("R1 led in reset", 32'(led_o), 32'h0);
    do_reset(1'b0);
    t_reset;
    t_id;
    t_led;
    t_flags;
    t_nv;
    t_resets;
    t_card;
    t_flash;
    t_misc;
    t_unmapped;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule